// File: doc/BRIEF.md
# Synchronous Receiver Sync Hunt and Leading-Sync Strip

This block sits behind the bit shifters of a group of synchronous receive lines. Each lane watches its serial stream for the sync character chosen for it. Until that character is seen, the lane does not know where characters begin or end. When the character is seen, the lane fixes its character framing and then builds 8-bit characters from the bits that follow. It hands each finished character on with a one-clock valid strobe.

The group holds two sync characters, A and B. Each lane has a selection bit that picks one of them. The selection bits sit in a small bank that a control write updates. The write changes the bit only when the control strobe is asserted in the same write.

Sync characters are removed in two tiers:
- The sync character that established framing is always discarded.
- When a lane's strip option is set, any further sync characters before the first non-sync character are also discarded.
- After the first non-sync character has gone out, sync characters are passed as ordinary data until the lane is disabled.

Each lane runs a three-state machine:

| State | Meaning |
|---|---|
| HUNT | Searching for the sync character, framing unknown |
| LEAD | Framed, and no non-sync character delivered yet |
| DATA | Free-running; every character is delivered |

The transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| Match | HUNT | LEAD | The last 8 bits equal the selected sync character |
| Lead-drop | LEAD | LEAD | A sync character arrives with strip set; it is discarded |
| Lead-pass | LEAD | LEAD | A sync character arrives with strip clear; it is delivered |
| Open | LEAD | DATA | A non-sync character arrives; it is delivered |
| Drop-enable | any | HUNT | The lane enable is clear |

Top module: `sdr_group_rx`

## Requirements
- R1: After reset, every selection bit is 0 (sync A), every lane reports not synchronised, and no character valid is asserted.
- R2: A lane's selection bit takes the value of `ctl_sel` only on a clock where `ctl_wr` and `ctl_strobe` are both high. The lane is chosen by `ctl_lane`. A write without the strobe leaves every selection bit unchanged.
- R3: A selection bit of 0 makes the lane use `sync_a`, and a value of 1 makes it use `sync_b`. This applies both to the hunt and to the leading-sync test.
- R4: In HUNT, on every bit tick the lane compares its last 8 received bits with the selected sync character. A match counts only once at least 8 bits have arrived since the lane entered HUNT. On a match, `lane_synced` rises on the next clock, and character framing starts with the next bit.
- R5: The sync character that achieved framing is never delivered, whatever the strip option.
- R6: With strip set, sync characters received in LEAD are discarded.
- R7: With strip clear, sync characters received in LEAD are delivered.
- R8: Once a non-sync character has been delivered, later sync characters are delivered even with strip set.
- R9: Characters are assembled least significant bit first. The first bit received after framing becomes bit 0. Each character produces exactly one clock of `char_valid` for its lane, with the character on that lane's slice of `char_data`.
- R10: Clearing a lane's enable returns it to HUNT on the next clock. `lane_synced` goes low, and a partly assembled character is discarded. On re-enable, the lane hunts afresh and strips leading syncs again.
- R11: A clock without the lane's bit tick neither shifts nor counts, so gaps between bits do not change the delivered characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_a | input | CHAR_W | Group sync character A |
| sync_b | input | CHAR_W | Group sync character B |
| ctl_wr | input | 1 | Control write |
| ctl_strobe | input | 1 | Control strobe; must accompany a write to update a selection bit |
| ctl_lane | input | LANE_W | Lane addressed by the control write |
| ctl_sel | input | 1 | New selection bit (0 = A, 1 = B) |
| lane_en | input | LANES | Per-lane receiver enable |
| lane_strip | input | LANES | Per-lane option to strip leading syncs |
| lane_tick | input | LANES | Per-lane bit-time strobe |
| lane_bit | input | LANES | Per-lane received bit, valid with its tick |
| char_data | output | LANES*CHAR_W | Per-lane delivered character; lane i occupies bits [i*CHAR_W +: CHAR_W] |
| char_valid | output | LANES | Per-lane one-clock character strobe |
| lane_synced | output | LANES | Lane is framed (LEAD or DATA) |
| lane_sel | output | LANES | Current per-lane sync selection bit |

## Verification
The lane's internal state shows at the ports on the next clock:
- A wrong lane state shows on `lane_synced`.
- A wrong bit counter shows as a mis-framed character, or as a valid strobe on the wrong clock.
- A wrong strip decision shows as an extra or missing `char_valid` when a LEAD character completes.

A behavioural model of each lane is compared with every output on every clock. A fault therefore surfaces no later than the end of the character it corrupts. Directed sequences also check the lists of delivered characters. These sequences cover a framing sync followed by repeated syncs, a non-sync character, and a late sync. They also cover an all-zero pattern at the fill boundary and ticks spaced by idle clocks.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LEAD = 2'd1,
        ST_DATA = 2'd2
    } sdr_state_e;

endpackage

// File: rtl/sdr_sel_bank.sv
module sdr_sel_bank #(
    parameter int LANES  = 4,
    parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              strobe,
    input  logic [LANE_W-1:0] lane,
    input  logic              sel_in,
    output logic [LANES-1:0]  sel_q
);

    logic [LANES-1:0] sel_d;

    always_comb begin
        sel_d = sel_q;
        if (wr && strobe) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane == LANE_W'(i)) begin
                    sel_d[i] = sel_in;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

endmodule

// File: rtl/sdr_lane_framer.sv
module sdr_lane_framer
    import sdr_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              rx_bit,
    input  logic              strip,
    input  logic [CHAR_W-1:0] pattern,
    output logic [CHAR_W-1:0] data_o,
    output logic              valid_o,
    output logic              synced_o
);

    localparam int CW = $clog2(CHAR_W + 1);
    localparam logic [CW-1:0] LAST = CW'(CHAR_W - 1);
    localparam logic [CW-1:0] FULL = CW'(CHAR_W);

    sdr_state_e        state_q, state_d;
    logic [CHAR_W-1:0] shreg_q, shreg_d;
    logic [CHAR_W-1:0] shifted;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic              valid_d;
    logic [CHAR_W-1:0] data_d;
    logic              is_sync;

    assign shifted = {rx_bit, shreg_q[CHAR_W-1:1]};
    assign is_sync = (shifted == pattern);

    always_comb begin
        state_d = state_q;
        shreg_d = shreg_q;
        cnt_d   = cnt_q;
        valid_d = 1'b0;
        data_d  = data_o;
        unique case (state_q)
            ST_HUNT: begin
                if (tick) begin
                    shreg_d = shifted;
                    if (cnt_q != FULL) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                    if ((cnt_q >= LAST) && is_sync) begin
                        state_d = ST_LEAD;
                        cnt_d   = '0;
                        shreg_d = '0;
                    end
                end
            end
            ST_LEAD, ST_DATA: begin
                if (tick) begin
                    shreg_d = shifted;
                    if (cnt_q == LAST) begin
                        cnt_d = '0;
                        if ((state_q == ST_LEAD) && is_sync && strip) begin
                            valid_d = 1'b0;
                        end else begin
                            valid_d = 1'b1;
                            data_d  = shifted;
                        end
                        if ((state_q == ST_LEAD) && !is_sync) begin
                            state_d = ST_DATA;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_HUNT;
                cnt_d   = '0;
            end
        endcase
        if (!en) begin
            state_d = ST_HUNT;
            shreg_d = '0;
            cnt_d   = '0;
            valid_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            shreg_q <= shreg_d;
            cnt_q   <= cnt_d;
            valid_o <= valid_d;
            data_o  <= data_d;
        end
    end

    assign synced_o = (state_q != ST_HUNT);

endmodule

// File: rtl/sdr_group_rx.sv
module sdr_group_rx #(
    parameter int LANES  = 4,
    parameter int CHAR_W = 8,
    parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CHAR_W-1:0]       sync_a,
    input  logic [CHAR_W-1:0]       sync_b,
    input  logic                    ctl_wr,
    input  logic                    ctl_strobe,
    input  logic [LANE_W-1:0]       ctl_lane,
    input  logic                    ctl_sel,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES-1:0]        lane_strip,
    input  logic [LANES-1:0]        lane_tick,
    input  logic [LANES-1:0]        lane_bit,
    output logic [LANES*CHAR_W-1:0] char_data,
    output logic [LANES-1:0]        char_valid,
    output logic [LANES-1:0]        lane_synced,
    output logic [LANES-1:0]        lane_sel
);

    sdr_sel_bank #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctl_wr),
        .strobe (ctl_strobe),
        .lane   (ctl_lane),
        .sel_in (ctl_sel),
        .sel_q  (lane_sel)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CHAR_W-1:0] pat;

        assign pat = lane_sel[g] ? sync_b : sync_a;

        sdr_lane_framer #(
            .CHAR_W (CHAR_W)
        ) u_frm (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (lane_en[g]),
            .tick     (lane_tick[g]),
            .rx_bit   (lane_bit[g]),
            .strip    (lane_strip[g]),
            .pattern  (pat),
            .data_o   (char_data[g*CHAR_W +: CHAR_W]),
            .valid_o  (char_valid[g]),
            .synced_o (lane_synced[g])
        );
    end

endmodule

// File: rtl/sdr_group_rx_chk.sv
module sdr_group_rx_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             ctl_strobe,
    input logic [LANES-1:0] lane_en,
    input logic [LANES-1:0] lane_tick,
    input logic [LANES-1:0] char_valid,
    input logic [LANES-1:0] lane_synced,
    input logic [LANES-1:0] lane_sel
);

    // R2: without write plus strobe the selection bits hold
    a_r2_sel_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && ctl_strobe) |=> $stable(lane_sel));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R10: a disabled lane is back in hunt on the next clock
        a_r10_disable_hunts: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_en[g] |=> !lane_synced[g]);

        // R5: nothing is delivered while hunting
        a_r5_no_char_in_hunt: assert property (@(posedge clk) disable iff (!rst_n)
            char_valid[g] |-> lane_synced[g]);

        // R9: the character strobe lasts one clock
        a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            char_valid[g] |=> !char_valid[g]);

        // R4: framing is gained only on an enabled bit tick
        a_r4_sync_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
            (!lane_synced[g] && !(lane_en[g] && lane_tick[g])) |=> !lane_synced[g]);

        // R11: a clock without a tick delivers nothing
        a_r11_no_tick_no_char: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_tick[g] |=> !char_valid[g]);
    end

endmodule

bind sdr_group_rx sdr_group_rx_chk #(
    .LANES (LANES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_strobe  (ctl_strobe),
    .lane_en     (lane_en),
    .lane_tick   (lane_tick),
    .char_valid  (char_valid),
    .lane_synced (lane_synced),
    .lane_sel    (lane_sel)
);

// File: tb/sim_sdr_group_rx.sv
module sim_sdr_group_rx;

    localparam int L = 4;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   sync_a = 8'h16;
    logic [W-1:0]   sync_b = 8'h32;
    logic           ctl_wr = 1'b0;
    logic           ctl_strobe = 1'b0;
    logic [1:0]     ctl_lane = '0;
    logic           ctl_sel = 1'b0;
    logic [L-1:0]   lane_en = '0;
    logic [L-1:0]   lane_strip = '0;
    logic [L-1:0]   lane_tick = '0;
    logic [L-1:0]   lane_bit = '0;
    logic [L*W-1:0] char_data;
    logic [L-1:0]   char_valid;
    logic [L-1:0]   lane_synced;
    logic [L-1:0]   lane_sel;

    always #2.5 clk = ~clk;

    sdr_group_rx #(.LANES(L), .CHAR_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_a(sync_a), .sync_b(sync_b),
        .ctl_wr(ctl_wr), .ctl_strobe(ctl_strobe), .ctl_lane(ctl_lane), .ctl_sel(ctl_sel),
        .lane_en(lane_en), .lane_strip(lane_strip), .lane_tick(lane_tick), .lane_bit(lane_bit),
        .char_data(char_data), .char_valid(char_valid), .lane_synced(lane_synced),
        .lane_sel(lane_sel)
    );

    int checks = 0;
    int errors = 0;
    int m_mode [L];
    int m_fill [L];
    int m_sh [L];
    int m_cnt [L];
    int m_sel [L];
    int e_valid [L];
    int e_data [L];
    int vcount [L];
    int gotq [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %0h exp %0h", req, act, exp);
        end
    endtask

    // behavioural lane model: one clock edge worth of effect
    task automatic model_update();
        for (int i = 0; i < L; i++) begin
            int sv;
            int b;
            sv = (m_sel[i] != 0) ? int'(sync_b) : int'(sync_a);
            b = int'(lane_bit[i]);
            e_valid[i] = 0;
            if (!rst_n || !lane_en[i]) begin
                m_mode[i] = 0; m_fill[i] = 0; m_sh[i] = 0; m_cnt[i] = 0;
            end else if (lane_tick[i]) begin
                m_sh[i] = (m_sh[i] >> 1) | (b << 7);
                if (m_mode[i] == 0) begin
                    if (m_fill[i] < 8) m_fill[i]++;
                    if (m_fill[i] >= 8 && m_sh[i] == sv) begin
                        m_mode[i] = 1; m_cnt[i] = 0; m_sh[i] = 0;
                    end
                end else begin
                    m_cnt[i]++;
                    if (m_cnt[i] == 8) begin
                        m_cnt[i] = 0;
                        if (!(m_mode[i] == 1 && m_sh[i] == sv && lane_strip[i])) begin
                            e_valid[i] = 1;
                            e_data[i] = m_sh[i];
                        end
                        if (m_mode[i] == 1 && m_sh[i] != sv) m_mode[i] = 2;
                    end
                end
            end
        end
        if (!rst_n) begin
            for (int i = 0; i < L; i++) m_sel[i] = 0;
        end else if (ctl_wr && ctl_strobe) begin
            m_sel[ctl_lane] = int'(ctl_sel);
        end
    endtask

    task automatic compare();
        for (int i = 0; i < L; i++) begin
            int d;
            d = int'(char_data[i*W +: W]);
            check(lane_synced[i] == (m_mode[i] != 0), "R4 synced", int'(lane_synced[i]), int'(m_mode[i] != 0));
            check(char_valid[i] == e_valid[i][0], "R6 valid", int'(char_valid[i]), e_valid[i]);
            if (char_valid[i] && e_valid[i] != 0)
                check(d == e_data[i], "R9 data", d, e_data[i]);
            check(lane_sel[i] == m_sel[i][0], "R2 sel", int'(lane_sel[i]), m_sel[i]);
            if (char_valid[i]) begin
                gotq.push_back(i * 256 + d);
                vcount[i]++;
            end
        end
    endtask

    task automatic cyc();
        model_update();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic send_byte(input int ln, input logic [7:0] b, input int gap);
        for (int k = 0; k < 8; k++) begin
            lane_bit[ln] = b[k];
            lane_tick[ln] = 1'b1;
            cyc();
            lane_tick[ln] = 1'b0;
            for (int g = 0; g < gap; g++) cyc();
        end
    endtask

    task automatic expect_seq(input int ln, input int exp[$], input string req);
        int got[$];
        foreach (gotq[k]) if ((gotq[k] >> 8) == ln) got.push_back(gotq[k] & 255);
        check(got.size() == exp.size(), req, got.size(), exp.size());
        for (int k = 0; k < exp.size() && k < got.size(); k++)
            check(got[k] == exp[k], req, got[k], exp[k]);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act 0 exp 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seq[$];
        for (int i = 0; i < L; i++) begin
            m_mode[i] = 0; m_fill[i] = 0; m_sh[i] = 0; m_cnt[i] = 0;
            m_sel[i] = 0; e_valid[i] = 0; e_data[i] = 0; vcount[i] = 0;
        end
        repeat (3) @(negedge clk);
        cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        check(lane_sel == '0, "R1 sel", int'(lane_sel), 0);
        check(lane_synced == '0, "R1 synced", int'(lane_synced), 0);
        check(char_valid == '0, "R1 valid", int'(char_valid), 0);

        // R2 write without strobe is ignored, with strobe takes effect
        ctl_wr = 1'b1; ctl_strobe = 1'b0; ctl_lane = 2'd1; ctl_sel = 1'b1;
        cyc();
        ctl_wr = 1'b0;
        cyc();
        check(lane_sel == 4'b0000, "R2 no strobe", int'(lane_sel), 0);
        ctl_wr = 1'b1; ctl_strobe = 1'b1;
        cyc();
        ctl_wr = 1'b0; ctl_strobe = 1'b0;
        cyc();
        check(lane_sel == 4'b0010, "R2 strobe", int'(lane_sel), 2);

        // R5 R6 R8 R9: lane 0, sync A, strip on
        lane_en[0] = 1'b1; lane_strip[0] = 1'b1;
        gotq.delete();
        send_byte(0, 8'h00, 0);
        send_byte(0, 8'h16, 0);
        send_byte(0, 8'h16, 0);
        send_byte(0, 8'h16, 0);
        send_byte(0, 8'h41, 0);
        send_byte(0, 8'h16, 0);
        send_byte(0, 8'h42, 0);
        repeat (2) cyc();
        seq = '{8'h41, 8'h16, 8'h42};
        expect_seq(0, seq, "R6 R8 lane0 sequence");
        check(vcount[0] == 3, "R9 one strobe per char", vcount[0], 3);

        // R3 R5 R7: lane 1 on sync B, strip off
        lane_en[1] = 1'b1; lane_strip[1] = 1'b0;
        gotq.delete();
        send_byte(1, 8'h00, 0);
        send_byte(1, 8'h32, 0);
        send_byte(1, 8'h32, 0);
        send_byte(1, 8'h55, 0);
        repeat (2) cyc();
        seq = '{8'h32, 8'h55};
        expect_seq(1, seq, "R3 R7 lane1 sequence");

        // R10: drop enable mid-character, then resynchronise
        for (int k = 0; k < 4; k++) begin
            lane_bit[0] = 1'b1; lane_tick[0] = 1'b1; cyc();
        end
        lane_tick[0] = 1'b0;
        lane_en[0] = 1'b0;
        cyc();
        check(lane_synced[0] == 1'b0, "R10 hunt after disable", int'(lane_synced[0]), 0);
        lane_en[0] = 1'b1;
        gotq.delete();
        send_byte(0, 8'h16, 0);
        send_byte(0, 8'h16, 0);
        send_byte(0, 8'h77, 0);
        repeat (2) cyc();
        seq = '{8'h77};
        expect_seq(0, seq, "R10 resync strips again");

        // R4: all-zero pattern needs 8 bits since hunt entry
        lane_en[0] = 1'b0; lane_en[1] = 1'b0;
        cyc();
        sync_a = 8'h00;
        lane_en[3] = 1'b1; lane_strip[3] = 1'b1;
        for (int k = 0; k < 7; k++) begin
            lane_bit[3] = 1'b0; lane_tick[3] = 1'b1; cyc();
        end
        check(lane_synced[3] == 1'b0, "R4 seven bits no sync", int'(lane_synced[3]), 0);
        cyc();
        check(lane_synced[3] == 1'b1, "R4 eighth bit syncs", int'(lane_synced[3]), 1);
        lane_tick[3] = 1'b0; lane_en[3] = 1'b0;
        cyc();
        sync_a = 8'h16;
        cyc();

        // R11: gaps between ticks
        lane_en[3] = 1'b1;
        gotq.delete();
        send_byte(3, 8'h00, 2);
        send_byte(3, 8'h16, 2);
        send_byte(3, 8'h5A, 2);
        repeat (2) cyc();
        seq = '{8'h5A};
        expect_seq(3, seq, "R11 gapped ticks");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule